// File: doc/BRIEF.md
# Composite Sync Classifier and Burst Gate

This block sits at the front of a video encoder's timing logic. It merges the separate horizontal and vertical sync inputs into one active-low composite sync by taking their XNOR. When the vertical input is tied high, a ready-made composite sync on the horizontal input passes through unchanged. The merged sync is retimed by two flops clocked at twice the colour subcarrier frequency. Every later decision uses only this sampled copy.

The block measures each low pulse in sample clocks and sorts it by width. A pulse can be a line sync, an equalising pulse, a broad (serration) pulse, or a width that fits no class. Each falling edge opens a short window for clamping the chroma modulators. Only a pulse judged to be a line sync arms the colour burst gate. The gate opens a fixed number of clocks after that pulse's falling edge and stays open for a fixed count. The start and the length of the gate depend on the selected colour standard. Three consecutive broad pulses raise a vertical blanking flag. The flag drops after a set number of line syncs.

Top module: `csync_burst_gate`

## Requirements
- R1: `csync_o` equals the XNOR of `hsync_in` and `vsync_in`, delayed by two sample clocks. With `vsync_in` high it follows `hsync_in`.
- R2: While `rst` is high, and afterwards until the first low pulse seen after reset has ended, `burst_o`, `clamp_o` and `vblank_o` are low and `csync_o` is high. That first pulse opens no window and is not classified.
- R3: A pulse's width is the number of clocks `csync_o` stays low. The classes are:
  - width below HS_MIN (25): equalising;
  - HS_MIN to HS_MAX (25 to 36): line sync;
  - BROAD_MIN (71) or more: broad;
  - anything else: no class.
  Only line syncs produce a burst.
- R4: With `pal_sel` = 0, a line sync's burst gate is high from 38 clocks after the cycle in which `csync_o` fell, for 18 clocks.
- R5: With `pal_sel` = 1, the burst gate starts 47 clocks after the fall and lasts 20 clocks.
- R6: After every counted falling edge of any class, `clamp_o` is high from 2 clocks after the fall, for 6 clocks.
- R7: `vblank_o` rises one clock after the end of the third consecutive broad pulse. Any pulse that is not broad restarts the count.
- R8: While `vblank_o` is high, only line syncs are counted. `vblank_o` falls one clock after the end of the fourth (VB_HLINES) line sync.
- R9: A falling edge that arrives while a burst gate is open ends it. `burst_o` is low from the clock after `csync_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at twice the subcarrier frequency |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync, or composite sync, active low |
| vsync_in | input | 1 | Vertical sync, active low; tie high for composite input |
| pal_sel | input | 1 | 1 selects PAL burst timing, 0 selects NTSC |
| csync_o | output | 1 | Sampled composite sync, active low |
| burst_o | output | 1 | Colour burst gate |
| clamp_o | output | 1 | Chroma clamp window |
| vblank_o | output | 1 | Vertical blanking flag |

## Verification
Two things can happen in the same cycle: a burst gate closing and a new pulse's measurement and clamp window starting. This happens when a falling edge arrives while the gate is still open. The bench provokes it with shortened lines in both standards. NTSC uses a 45-clock line and PAL a 55-clock line. It expects a truncated gate whose length is the line length minus the burst start plus one. The next clamp window and burst must then start on schedule, counted from the new edge. The bench also expects the blanking flag to clear on the same edge that arms a line sync's burst.

// File: rtl/csync_burst_gate.sv
module csync_burst_gate #(
  parameter int CW             = 8,
  parameter int HS_MIN         = 25,
  parameter int HS_MAX         = 36,
  parameter int BROAD_MIN      = 71,
  parameter int CLAMP_AT       = 2,
  parameter int CLAMP_LEN      = 6,
  parameter int NTSC_BURST_AT  = 38,
  parameter int NTSC_BURST_LEN = 18,
  parameter int PAL_BURST_AT   = 47,
  parameter int PAL_BURST_LEN  = 20,
  parameter int VB_HLINES      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic pal_sel,
  output logic csync_o,
  output logic burst_o,
  output logic clamp_o,
  output logic vblank_o
);
  localparam int VBW = $clog2(VB_HLINES + 1);
  localparam logic [CW-1:0] POS_SAT = '1;
  localparam logic [CW-1:0] CL_LO   = CW'(CLAMP_AT);
  localparam logic [CW-1:0] CL_HI   = CW'(CLAMP_AT + CLAMP_LEN);

  typedef enum logic [1:0] {PK_EQ, PK_LINE, PK_BROAD, PK_NONE} pkind_t;

  logic s1, s2, s3;
  logic [CW-1:0] pos;
  logic live, arm, line_ok, vb;
  logic [1:0] run;
  logic [VBW-1:0] hcnt;
  pkind_t kind;
  logic [CW-1:0] b_lo, b_hi;

  wire fall = s3 & ~s2;
  wire rise = ~s3 & s2;

  assign b_lo = pal_sel ? CW'(PAL_BURST_AT) : CW'(NTSC_BURST_AT);
  assign b_hi = b_lo + (pal_sel ? CW'(PAL_BURST_LEN) : CW'(NTSC_BURST_LEN));

  always_comb begin
    if (pos < CW'(HS_MIN))          kind = PK_EQ;
    else if (pos <= CW'(HS_MAX))    kind = PK_LINE;
    else if (pos >= CW'(BROAD_MIN)) kind = PK_BROAD;
    else                            kind = PK_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= ~(hsync_in ^ vsync_in);
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  pos <= POS_SAT;
    else if (fall)            pos <= CW'(1);
    else if (pos != POS_SAT)  pos <= pos + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      arm     <= 1'b0;
      line_ok <= 1'b0;
      vb      <= 1'b0;
      run     <= 2'd0;
      hcnt    <= '0;
    end else begin
      if (fall) begin
        arm     <= live;
        line_ok <= 1'b0;
      end
      if (rise) begin
        live <= 1'b1;
        if (arm) begin
          line_ok <= (kind == PK_LINE);
          if (kind == PK_BROAD) begin
            if (run >= 2'd2) begin
              vb   <= 1'b1;
              hcnt <= '0;
            end
            if (run != 2'd3) run <= run + 2'd1;
          end else begin
            run <= 2'd0;
            if (kind == PK_LINE && vb) begin
              if (hcnt == VBW'(VB_HLINES - 1)) begin
                vb   <= 1'b0;
                hcnt <= '0;
              end else begin
                hcnt <= hcnt + VBW'(1);
              end
            end
          end
        end
      end
    end
  end

  assign csync_o  = s2;
  assign burst_o  = line_ok & (pos >= b_lo) & (pos < b_hi);
  assign clamp_o  = arm & (pos >= CL_LO) & (pos < CL_HI);
  assign vblank_o = vb;

endmodule

// File: rtl/csync_burst_gate_chk.sv
module csync_burst_gate_chk #(
  parameter int CLAMP_LEN      = 6,
  parameter int NTSC_BURST_LEN = 18,
  parameter int PAL_BURST_LEN  = 20
) (
  input logic clk,
  input logic rst,
  input logic hsync_in,
  input logic vsync_in,
  input logic pal_sel,
  input logic csync_o,
  input logic burst_o,
  input logic clamp_o,
  input logic vblank_o
);
  logic [2:0] age;
  logic x1, x2, cs_d, seen;
  int brun, crun;

  always_ff @(posedge clk) begin
    x1 <= ~(hsync_in ^ vsync_in);
    x2 <= x1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= '0;
      cs_d <= 1'b1;
      seen <= 1'b0;
      brun <= 0;
      crun <= 0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      cs_d <= csync_o;
      if (csync_o && !cs_d) seen <= 1'b1;
      brun <= burst_o ? brun + 1 : 0;
      crun <= clamp_o ? crun + 1 : 0;
    end
  end

  AST_CSYNC_XNOR: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> (csync_o == x2)); // R1
  AST_QUIET_UNTIL_FIRST: assert property (@(posedge clk) disable iff (rst)
    !seen |-> !(burst_o || clamp_o || vblank_o)); // R2
  AST_BURST_IN_SYNC_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_o) |-> csync_o); // R4
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    burst_o |-> (brun < (pal_sel ? PAL_BURST_LEN : NTSC_BURST_LEN))); // R5
  AST_CLAMP_LEN: assert property (@(posedge clk) disable iff (rst)
    clamp_o |-> (crun < CLAMP_LEN)); // R6
  AST_FALL_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    $fell(csync_o) |=> !burst_o); // R9
  AST_VBLANK_AT_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    (vblank_o != $past(vblank_o)) |-> $past(csync_o && !cs_d)); // R7
endmodule

bind csync_burst_gate csync_burst_gate_chk #(
  .CLAMP_LEN(CLAMP_LEN),
  .NTSC_BURST_LEN(NTSC_BURST_LEN),
  .PAL_BURST_LEN(PAL_BURST_LEN)
) u_chk (.*);

// File: tb/test_csync_burst_gate.sv
module test_csync_burst_gate;
  localparam int HS_MIN = 25, HS_MAX = 36, BROAD_MIN = 71;
  localparam int CL_AT = 2, CL_LEN = 6;
  localparam int N_AT = 38, N_LEN = 18, P_AT = 47, P_LEN = 20;
  localparam int VBL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic hsync_in = 1'b1, vsync_in = 1'b1, pal_sel = 1'b0;
  logic csync_o, burst_o, clamp_o, vblank_o;

  csync_burst_gate i_csync_burst_gate (.*);

  always #10 clk = ~clk;

  typedef struct { int start; int len; string req; } win_t;
  typedef struct { int at; bit lvl; string req; } ev_t;
  win_t bq[$], cq[$];
  ev_t  vq[$];
  int cyc = 0, n_chk = 0, n_fail = 0, obs_b = 0, obs_c = 0;
  bit done = 1'b0;
  bit m_live = 1'b0, m_vb = 1'b0;
  int m_run = 0, m_hcnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(int w, int line, bit via_v);
    int c, r, at, len, before_b;
    bit want_b;
    @(negedge clk);
    c = cyc + 2;
    r = c + w;
    want_b = 1'b0;
    before_b = obs_b;
    if (via_v) begin hsync_in = 1'b1; vsync_in = 1'b0; end
    else       begin hsync_in = 1'b0; vsync_in = 1'b1; end
    if (!m_live) m_live = 1'b1;
    else begin
      cq.push_back('{c + CL_AT, CL_LEN, "R6"});
      if (w >= BROAD_MIN) begin
        if (m_run >= 2 && !m_vb) vq.push_back('{r + 1, 1'b1, "R7"});
        if (m_run >= 2) begin m_vb = 1'b1; m_hcnt = 0; end
        if (m_run < 3) m_run++;
      end else begin
        m_run = 0;
        if (w >= HS_MIN && w <= HS_MAX) begin
          at  = pal_sel ? P_AT : N_AT;
          len = pal_sel ? P_LEN : N_LEN;
          want_b = 1'b1;
          if (line - at + 1 < len)
            bq.push_back('{c + at, line - at + 1, "R9"});
          else
            bq.push_back('{c + at, len, pal_sel ? "R5" : "R4"});
          if (m_vb) begin
            m_hcnt++;
            if (m_hcnt == VBL) begin
              m_vb = 1'b0; m_hcnt = 0;
              vq.push_back('{r + 1, 1'b0, "R8"});
            end
          end
        end
      end
    end
    repeat (w) @(negedge clk);
    hsync_in = 1'b1; vsync_in = 1'b1;
    repeat (line - w - 1) @(negedge clk);
    if (!want_b) check(obs_b == before_b, "R3", "burst after non-line pulse", obs_b - before_b, 0);
  endtask

  initial begin : monitor
    bit bp = 0, cp = 0, vp = 0, px = 1;
    int bs = 0, bl = 0, cs = 0, cl = 0, age = 0;
    win_t it;
    ev_t ev;
    forever begin
      @(posedge clk); #5;
      if (rst) begin age = 0; continue; end
      if (age >= 2) check(csync_o == px, "R1", "csync_o", csync_o, px);
      px = ~(hsync_in ^ vsync_in);
      age++;
      if (burst_o && !bp) begin bs = cyc; bl = 0; end
      if (burst_o) bl++;
      if (!burst_o && bp) begin
        obs_b++;
        if (bq.size() == 0) check(0, "R3", "unexpected burst start", bs, -1);
        else begin
          it = bq.pop_front();
          check(bs == it.start, it.req, "burst start", bs, it.start);
          check(bl == it.len, it.req, "burst length", bl, it.len);
        end
      end
      if (clamp_o && !cp) begin cs = cyc; cl = 0; end
      if (clamp_o) cl++;
      if (!clamp_o && cp) begin
        obs_c++;
        if (cq.size() == 0) check(0, "R2", "unexpected clamp start", cs, -1);
        else begin
          it = cq.pop_front();
          check(cs == it.start, it.req, "clamp start", cs, it.start);
          check(cl == it.len, it.req, "clamp length", cl, it.len);
        end
      end
      if (vblank_o != vp) begin
        if (vq.size() == 0) check(0, "R7", "unexpected vblank change", cyc, -1);
        else begin
          ev = vq.pop_front();
          check(cyc == ev.at, ev.req, "vblank change cycle", cyc, ev.at);
          check(vblank_o == ev.lvl, ev.req, "vblank level", vblank_o, ev.lvl);
        end
      end
      bp = burst_o; cp = clamp_o; vp = vblank_o;
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    check(csync_o == 1'b1 && !burst_o && !clamp_o && !vblank_o, "R2", "reset outputs",
          {csync_o, burst_o, clamp_o, vblank_o}, 4'b1000);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    pulse(30, 100, 0);
    repeat (5) @(negedge clk);
    check(obs_b == 0 && obs_c == 0, "R2", "windows from first pulse", obs_b + obs_c, 0);
    // NTSC line syncs and width boundaries (R3, R4)
    pulse(30, 100, 0);
    pulse(25, 100, 1);
    pulse(36, 100, 0);
    pulse(24, 100, 0);
    pulse(37, 100, 0);
    pulse(70, 100, 1);
    pulse(10, 50, 0);
    pulse(10, 50, 0);
    // vertical interval (R7, R8)
    pulse(80, 100, 0);
    pulse(80, 100, 0);
    pulse(50, 100, 0);
    pulse(80, 100, 1);
    pulse(80, 100, 0);
    pulse(71, 100, 0);
    pulse(80, 100, 0);
    pulse(10, 50, 0);
    pulse(10, 50, 0);
    for (int i = 0; i < VBL; i++) pulse(30, 100, 0);
    pulse(30, 100, 0);
    // truncation by an early edge, NTSC (R9)
    pulse(30, 45, 0);
    pulse(30, 100, 0);
    repeat (20) @(negedge clk);
    pal_sel = 1'b1;
    // PAL timing (R5) and truncation (R9)
    pulse(30, 100, 0);
    pulse(36, 100, 1);
    pulse(30, 55, 0);
    pulse(30, 100, 0);
    repeat (300) @(negedge clk);
    check(bq.size() == 0, "R4", "missing bursts", bq.size(), 0);
    check(cq.size() == 0, "R6", "missing clamps", cq.size(), 0);
    check(vq.size() == 0, "R8", "missing vblank changes", vq.size(), 0);
    check(vblank_o == 1'b0, "R8", "vblank at end", vblank_o, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule